// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Status Flags

This block performs the data-path arithmetic of a small 8-bit accumulator processor. Each cycle it takes an operation code, the accumulator, the index register X, an operand byte and the current status byte. It computes the result byte, the value for the index register and a new status byte. The result and status are captured in a register and appear one clock later.

Arithmetic follows the usual conventions for this processor family. Carry acts as "no borrow" on subtraction and comparison. A bit-test loads the top two operand bits into the sign and overflow flags. A combined operation masks the accumulator with X, subtracts the operand and writes the difference into X. The flags for interrupt-disable, decimal, break and the unused bit are never modified. Decimal arithmetic, register storage, decoding and memory access sit outside this block. Single-operand operations (shifts, rotates, increment, decrement) act on the operand byte, so a decoder that wants the accumulator form places the accumulator on the operand input.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered with a latency of one clock. While `rst_n` is low, `res_o`, `x_o` and `p_o` are all zero. Status bit positions are C=0, Z=1, I=2, D=3, B=4, U=5, V=6, N=7. Unless a requirement says otherwise, Z is set when the result byte is zero and N is a copy of result bit 7.
- R2: ADD (op 0): the 9-bit sum is A + M + C. `res_o` is its low byte and C is bit 8. V is set when A and M have the same sign and the sign of the result differs from A.
- R3: SUB (op 1): `res_o` is A − M − (1 − C). C is set when no borrow occurs. V is set when A and M differ in sign and the sign of the result differs from A.
- R4: Compare A (op 5) and compare X (op 6) evaluate register minus M. Z and N come from the low 8 bits, and C is set when register ≥ M, taken unsigned. V is unchanged and `res_o` equals A.
- R5: BIT (op 7): Z is set when (A AND M) is zero. N takes M bit 7 and V takes M bit 6. C is unchanged and `res_o` equals A.
- R6: AND (op 2), OR (op 3) and XOR (op 4) combine A with M into `res_o`. Only Z and N change.
- R7: Shift left (op 8) moves M bit 7 into C and puts 0 in bit 0. Shift right (op 9) moves M bit 0 into C and puts 0 in bit 7, so N is always clear. V is unchanged.
- R8: Rotate left (op 10) puts the old C into bit 0 and sends M bit 7 to C. Rotate right (op 11) puts the old C into bit 7 and sends M bit 0 to C.
- R9: Increment (op 12) and decrement (op 13) give M ± 1 modulo 256 in `res_o`. C and V are unchanged.
- R10: Mask-subtract (op 14) writes (A AND X) − M, modulo 256, into `x_o`. N, Z and C follow the compare rules on that difference. V is unchanged and `res_o` equals A.
- R11: Status bits I, D, B and U (bits 2–5) always pass through unchanged. Every operation except op 14 returns X unchanged on `x_o`. Op 15 is a no-operation: `res_o` is A and the status byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 4 | Operation code |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | Index register X value |
| m_in | input | 8 | Operand byte |
| p_in | input | 8 | Incoming status byte |
| res_o | output | 8 | Registered result byte |
| x_o | output | 8 | Registered new X value |
| p_o | output | 8 | Registered new status byte |

## Verification
The case hardest to reach is signed overflow on subtraction when a borrow comes in. It needs the operand signs to differ and the incoming carry to be clear, and the borrow has to be the thing that moves the result across the sign boundary. A value such as 0x80 minus 0x00 with a borrow shows this. Directed items cover that case and the neighbouring wrap points: 0x7F plus 1, 0xFF plus 1, decrement of zero, comparisons of equal values, and mask-subtract results that underflow. A long run of random items then mixes every operation code with random status bytes, so the pass-through bits and the unchanged-flag rules are checked under every operation.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_CMPA = 4'd5,
        OP_CMPX = 4'd6,
        OP_BIT  = 4'd7,
        OP_ASL  = 4'd8,
        OP_LSR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_ROR  = 4'd11,
        OP_INC  = 4'd12,
        OP_DEC  = 4'd13,
        OP_MSUB = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    localparam int F_C = 0;
    localparam int F_Z = 1;
    localparam int F_I = 2;
    localparam int F_D = 3;
    localparam int F_B = 4;
    localparam int F_U = 5;
    localparam int F_V = 6;
    localparam int F_N = 7;
    localparam int STAT_W = 8;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] rhs_eff;
    logic [W:0]   full;

    always_comb begin
        rhs_eff = sub ? ~rhs : rhs;
        full    = {1'b0, lhs} + {1'b0, rhs_eff} + {{W{1'b0}}, cin};
        sum     = full[W-1:0];
        cout    = full[W];
        ovf     = ~(lhs[MSB] ^ rhs_eff[MSB]) & (lhs[MSB] ^ full[MSB]);
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] din,
    input  logic         cin,
    input  logic         right,
    input  logic         rotate,
    output logic [W-1:0] dout,
    output logic         cout
);
    logic fill;

    always_comb begin
        fill = rotate ? cin : 1'b0;
        if (right) begin
            dout = {fill, din[W-1:1]};
            cout = din[0];
        end else begin
            dout = {din[W-2:0], fill};
            cout = din[W-1];
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            2'd0:    y = a & b;
            2'd1:    y = a | b;
            default: y = a ^ b;
        endcase
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   op,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] m_in,
    input  logic [STAT_W-1:0] p_in,
    output logic [W-1:0] res_o,
    output logic [W-1:0] x_o,
    output logic [STAT_W-1:0] p_o
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0]      res;
        logic [W-1:0]      xr;
        logic [STAT_W-1:0] p;
    } alu_state_t;

    alu_op_e    op_e;
    alu_state_t st_d, st_q;
    logic       live_q;

    logic [W-1:0] as_lhs, as_sum, sh_out, lg_out;
    logic         as_cin, as_sub, as_cout, as_ovf, sh_cout;
    logic [1:0]   lg_sel;

    assign op_e = alu_op_e'(op);

    always_comb begin
        as_lhs = a_in;
        as_cin = p_in[F_C];
        as_sub = 1'b1;
        unique case (op_e)
            OP_ADD:  as_sub = 1'b0;
            OP_SUB:  as_cin = p_in[F_C];
            OP_CMPX: begin as_lhs = x_in;        as_cin = 1'b1; end
            OP_MSUB: begin as_lhs = a_in & x_in; as_cin = 1'b1; end
            default: as_cin = 1'b1;
        endcase
        lg_sel = (op_e == OP_OR)  ? 2'd1 :
                 (op_e == OP_XOR) ? 2'd2 : 2'd0;
    end

    alu8_addsub #(.W(W)) u_addsub (
        .lhs(as_lhs), .rhs(m_in), .cin(as_cin), .sub(as_sub),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu8_shift #(.W(W)) u_shift (
        .din(m_in), .cin(p_in[F_C]),
        .right(op_e == OP_LSR || op_e == OP_ROR),
        .rotate(op_e == OP_ROL || op_e == OP_ROR),
        .dout(sh_out), .cout(sh_cout)
    );

    alu8_logic #(.W(W)) u_logic (
        .a(a_in), .b(m_in), .sel(lg_sel), .y(lg_out)
    );

    always_comb begin
        st_d.res = a_in;
        st_d.xr  = x_in;
        st_d.p   = p_in;
        unique case (op_e)
            OP_ADD, OP_SUB: begin
                st_d.res    = as_sum;
                st_d.p[F_C] = as_cout;
                st_d.p[F_V] = as_ovf;
                st_d.p[F_Z] = (as_sum == '0);
                st_d.p[F_N] = as_sum[MSB];
            end
            OP_CMPA, OP_CMPX: begin
                st_d.p[F_C] = as_cout;
                st_d.p[F_Z] = (as_sum == '0);
                st_d.p[F_N] = as_sum[MSB];
            end
            OP_MSUB: begin
                st_d.xr     = as_sum;
                st_d.p[F_C] = as_cout;
                st_d.p[F_Z] = (as_sum == '0);
                st_d.p[F_N] = as_sum[MSB];
            end
            OP_AND, OP_OR, OP_XOR: begin
                st_d.res    = lg_out;
                st_d.p[F_Z] = (lg_out == '0);
                st_d.p[F_N] = lg_out[MSB];
            end
            OP_BIT: begin
                st_d.p[F_Z] = ((a_in & m_in) == '0);
                st_d.p[F_N] = m_in[MSB];
                st_d.p[F_V] = m_in[MSB-1];
            end
            OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
                st_d.res    = sh_out;
                st_d.p[F_C] = sh_cout;
                st_d.p[F_Z] = (sh_out == '0);
                st_d.p[F_N] = sh_out[MSB];
            end
            OP_INC, OP_DEC: begin
                st_d.res    = (op_e == OP_INC) ? m_in + 1'b1 : m_in - 1'b1;
                st_d.p[F_Z] = (st_d.res == '0);
                st_d.p[F_N] = st_d.res[MSB];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            live_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            live_q <= 1'b1;
        end
    end

    assign res_o = st_q.res;
    assign x_o   = st_q.xr;
    assign p_o   = st_q.p;

    AST_KEEP_CTRL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> p_o[F_U:F_I] == $past(p_in[F_U:F_I])); // R11

    AST_X_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op) != OP_MSUB) |-> x_o == $past(x_in)); // R11

    AST_LSR_SIGN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op) == OP_LSR) |-> !p_o[F_N]); // R7

    AST_CMP_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op) == OP_CMPA || $past(op) == OP_CMPX))
        |-> (p_o[F_V] == $past(p_in[F_V]) && res_o == $past(a_in))); // R4

    AST_BIT_COPIES_NV: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(op) == OP_BIT)
        |-> p_o[F_N:F_V] == $past(m_in[MSB:MSB-1])); // R5

    AST_INCDEC_KEEP_CV: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op) == OP_INC || $past(op) == OP_DEC))
        |-> (p_o[F_C] == $past(p_in[F_C]) && p_o[F_V] == $past(p_in[F_V]))); // R9

    AST_ZERO_FLAG_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(op) == OP_ADD || $past(op) == OP_SUB))
        |-> p_o[F_Z] == (res_o == '0)); // R2
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op = '0;
    logic [7:0] a_in = '0, x_in = '0, m_in = '0, p_in = '0;
    logic [7:0] res_o, x_o, p_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        int         at;
        string      tag;
        logic [7:0] res;
        logic [7:0] xr;
        logic [7:0] p;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    alu8_core u_dut (
        .clk(clk), .rst_n(rst_n), .op(op), .a_in(a_in), .x_in(x_in),
        .m_in(m_in), .p_in(p_in), .res_o(res_o), .x_o(x_o), .p_o(p_o)
    );

    function automatic string tag_of(int o);
        case (o)
            0: return "R2";
            1: return "R3";
            2, 3, 4: return "R6";
            5, 6: return "R4";
            7: return "R5";
            8, 9: return "R7";
            10, 11: return "R8";
            12, 13: return "R9";
            14: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic item_t model(int o, logic [7:0] a, logic [7:0] x,
                                    logic [7:0] m, logic [7:0] p);
        item_t it;
        logic [8:0] s;
        logic [7:0] r;
        logic c;
        c      = p[0];
        it.res = a;
        it.xr  = x;
        it.p   = p;
        r      = a;
        case (o)
            0: begin
                s = {1'b0, a} + {1'b0, m} + {8'd0, c};
                r = s[7:0]; it.res = r; it.p[0] = s[8];
                it.p[6] = (a[7] == m[7]) && (r[7] != a[7]);
            end
            1: begin
                s = {1'b0, a} + {1'b0, ~m} + {8'd0, c};
                r = s[7:0]; it.res = r; it.p[0] = (int'(a) >= int'(m) + (c ? 0 : 1));
                it.p[6] = (a[7] != m[7]) && (r[7] != a[7]);
            end
            2: begin r = a & m; it.res = r; end
            3: begin r = a | m; it.res = r; end
            4: begin r = a ^ m; it.res = r; end
            5: begin r = a - m; it.p[0] = (a >= m); end
            6: begin r = x - m; it.p[0] = (x >= m); end
            7: begin
                it.p[1] = ((a & m) == 0); it.p[7] = m[7]; it.p[6] = m[6];
            end
            8:  begin r = {m[6:0], 1'b0}; it.p[0] = m[7]; it.res = r; end
            9:  begin r = {1'b0, m[7:1]}; it.p[0] = m[0]; it.res = r; end
            10: begin r = {m[6:0], c};    it.p[0] = m[7]; it.res = r; end
            11: begin r = {c, m[7:1]};    it.p[0] = m[0]; it.res = r; end
            12: begin r = m + 8'd1; it.res = r; end
            13: begin r = m - 8'd1; it.res = r; end
            14: begin
                r = (a & x) - m; it.xr = r; it.p[0] = ((a & x) >= m);
            end
            default: ;
        endcase
        if (o != 7 && o != 15) begin
            it.p[1] = (r == 0);
            it.p[7] = r[7];
        end
        return it;
    endfunction

    task automatic drive(int o, logic [7:0] a, logic [7:0] x, logic [7:0] m,
                         logic [7:0] p, string tag);
        item_t it;
        @(negedge clk);
        op = 4'(o); a_in = a; x_in = x; m_in = m; p_in = p;
        it     = model(o, a, x, m, p);
        it.at  = cyc;
        it.tag = (tag == "") ? tag_of(o) : tag;
        sb.push_back(it);
    endtask

    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at < cyc) begin
            item_t e;
            e = sb.pop_front();
            checks++;
            if (res_o !== e.res || x_o !== e.xr || p_o !== e.p) begin
                fails++;
                $display("FAIL %s: res=%h x=%h p=%h expected res=%h x=%h p=%h",
                         e.tag, res_o, x_o, p_o, e.res, e.xr, e.p);
            end
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        op = 4'd0; a_in = 8'h55; x_in = 8'h66; m_in = 8'h77; p_in = 8'hFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (res_o !== 8'h00 || x_o !== 8'h00 || p_o !== 8'h00) begin
            fails++;
            $display("FAIL R1: reset res=%h x=%h p=%h expected 00 00 00", res_o, x_o, p_o);
        end
        rst_n = 1'b1;

        // R2 corner cases: signed overflow, carry out with zero result
        drive(0, 8'h50, 0, 8'h50, 8'h00, "R2");
        drive(0, 8'hFF, 0, 8'h01, 8'h00, "R2");
        drive(0, 8'h7F, 0, 8'h00, 8'h01, "R2");
        // R3: borrow in pushes across the sign boundary
        drive(1, 8'h80, 0, 8'h00, 8'h00, "R3");
        drive(1, 8'h50, 0, 8'hB0, 8'h01, "R3");
        drive(1, 8'h00, 0, 8'h01, 8'h01, "R3");
        // R4 equal and less-than compares
        drive(5, 8'h42, 0, 8'h42, 8'h40, "R4");
        drive(6, 8'h00, 8'h10, 8'h20, 8'h41, "R4");
        // R5
        drive(7, 8'h0F, 0, 8'hC0, 8'h01, "R5");
        // R6
        drive(2, 8'hF0, 0, 8'h0F, 8'h00, "R6");
        // R7 / R8
        drive(9, 8'h00, 0, 8'h01, 8'h80, "R7");
        drive(8, 8'h00, 0, 8'h80, 8'h00, "R7");
        drive(11, 8'h00, 0, 8'h01, 8'h01, "R8");
        drive(10, 8'h00, 0, 8'h80, 8'h00, "R8");
        // R9 wrap in both directions
        drive(12, 8'h00, 0, 8'hFF, 8'h41, "R9");
        drive(13, 8'h00, 0, 8'h00, 8'h00, "R9");
        // R10 underflow and zero result
        drive(14, 8'hF3, 8'h3F, 8'h34, 8'h40, "R10");
        drive(14, 8'hFF, 8'h0F, 8'h0F, 8'h00, "R10");
        // R11 no-operation with all control bits set
        drive(15, 8'hAA, 8'hBB, 8'hCC, 8'h3C, "R11");
        drive(3, 8'h00, 8'h99, 8'h00, 8'h3C, "R11");

        for (int i = 0; i < 3000; i++) begin
            drive(i % 16, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "");
        end
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule